// File: doc/BRIEF.md
# Multi-Mode FSK Tone Modulator

This block turns a serial data bit into a stream of signed sine samples whose frequency encodes the bit. Four line modes are supported: two for a full-duplex low-speed channel (the calling side and the answering side) and two for an asymmetric channel (a fast forward channel and a slow return channel). Each mode owns a mark tone and a space tone. The bit goes to the tone generator as it is, with no rate conversion and no scrambling.

Tone synthesis uses a 24-bit phase accumulator that is stepped once per sample strobe. The strobe arrives at a fixed 9600 Hz rate. The top 8 accumulator bits address a 256-entry, 12-bit signed sine table. A change of bit or mode swaps only the phase increment, so the waveform never jumps in phase. Bit timing, line shaping, conversion to analog and reception belong to other blocks.

Top module: `fsk_tone_mod`

## Requirements
- R1: After reset, `sampleOut` is 0, `sampleValid` is 0 and the phase is 0.
- R2: Mode 2'b00 (low-speed, calling side) steps the phase by round(f·2^24/9600). f is 980 Hz when `dataBit`=1 (mark) and 1180 Hz when `dataBit`=0 (space).
- R3: Mode 2'b01 (low-speed, answering side) uses 1650 Hz for mark (`dataBit`=1) and 1850 Hz for space (`dataBit`=0).
- R4: Mode 2'b10 (forward channel) uses 1300 Hz for mark (`dataBit`=1) and 2100 Hz for space (`dataBit`=0).
- R5: Mode 2'b11 (return channel) uses 390 Hz for mark (`dataBit`=1) and 450 Hz for space (`dataBit`=0).
- R6: `sampleStb` may be high while `enable` is high. On the clock edge where that happens, the block loads `sampleOut` with round(2047·sin(2π·p/256)), within ±1 LSB, and raises `sampleValid` for exactly one cycle. Here p is the top 8 phase bits before the step. On the same edge the phase advances, modulo 2^24, by the increment that `mode` and `dataBit` select at that edge.
- R7: In a cycle with `enable` high and no strobe, the phase and `sampleOut` hold their values and `sampleValid` is 0.
- R8: A change of `dataBit` or `mode` alters only the increment and never resets the phase. The sample sequence stays continuous across tone changes.
- R9: While `enable` is low, `sampleOut` is 0, `sampleValid` is 0 and the phase is cleared. The first sample after `enable` rises is therefore sin(0) = 0.
- R10: A strobe on an edge where `enable` is low is ignored. Clearing takes priority, and no valid sample appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low clears phase and output |
| sampleStb | input | 1 | One-cycle strobe at the sample rate |
| dataBit | input | 1 | Data bit: 1 = mark, 0 = space |
| mode | input | 2 | Line mode select (see R2–R5) |
| sampleOut | output | 12 | Signed sine sample |
| sampleValid | output | 1 | High for one cycle when a new sample is out |

## Verification
Two functions can coincide on a single clock edge. The first case is a tone change on the edge that applies the step: the bench toggles `dataBit` and `mode` together with every strobe, and a phase model in the bench that accumulates increments checks each sample against a freshly computed sine. The second case is a falling `enable` on a strobe edge: the bench lowers `enable` in the same cycle as a strobe, after the phase has moved well away from zero. It expects a zero sample, no valid pulse, and a first sample of zero once `enable` returns.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

  typedef enum logic [1:0] {
    MODE_LS_CALL = 2'd0,
    MODE_LS_ANS  = 2'd1,
    MODE_FWD     = 2'd2,
    MODE_RET     = 2'd3
  } fsk_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;
    logic clear;
  } nco_ctl_t;

  // Tone frequency in Hz; mark (bit=1) is always the lower tone
  function automatic int unsigned toneHz(input logic [1:0] m, input logic isMark);
    int unsigned f;
    case (m)
      2'd0:    f = isMark ? 980  : 1180;
      2'd1:    f = isMark ? 1650 : 1850;
      2'd2:    f = isMark ? 1300 : 2100;
      default: f = isMark ? 390  : 450;
    endcase
    return f;
  endfunction

  // Rounded phase increment for a tone
  function automatic longint tuneWord(input int unsigned f, input int accW, input int fs);
    return ((longint'(f) << accW) + longint'(fs / 2)) / longint'(fs);
  endfunction

endpackage

// File: rtl/fsk_ctrl.sv
module fsk_ctrl
  import fsk_mod_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       sampleStb,
  input  logic       dataBit,
  input  logic [1:0] mode,
  output nco_ctl_t   ctl,
  output logic [2:0] toneSel
);

  always_comb begin
    ctl.clear = !enable;
    ctl.step  = enable && sampleStb;
    // Index: mode in the upper bits, space flag in the LSB
    toneSel   = {mode, !dataBit};
  end

  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.step, ctl.clear}));

  // R10
  stb_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && sampleStb) |-> !ctl.step);

endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom #(
  parameter int IDX_W  = 8,
  parameter int SAMP_W = 12
) (
  input  logic [IDX_W-1:0]         addr,
  output logic signed [SAMP_W-1:0] rdData
);

  localparam int     ENTRIES = 1 << IDX_W;
  localparam int     QTR     = ENTRIES / 4;
  localparam int     HALF    = ENTRIES / 2;
  localparam longint AMP     = (longint'(1) << (SAMP_W - 1)) - 1;
  localparam longint PI_Q30  = 64'sd3373259426;

  // Fixed-point series sine over a quarter wave, mirrored to a full turn
  function automatic int sineVal(input int i);
    longint x, term, t, sum, amp;
    int q, j, qi;
    q  = i / QTR;
    j  = i % QTR;
    qi = (q % 2 == 1) ? (QTR - j) : j;
    x  = (longint'(qi) * PI_Q30) / longint'(HALF);
    term = x;
    sum  = x;
    for (int k = 1; k < 8; k++) begin
      t    = (term * x) >>> 30;
      t    = (t * x) >>> 30;
      term = -(t / longint'((2 * k) * (2 * k + 1)));
      sum  = sum + term;
    end
    amp = (sum * AMP + (longint'(1) <<< 29)) >>> 30;
    return (q >= 2) ? -int'(amp) : int'(amp);
  endfunction

  logic signed [SAMP_W-1:0] romArr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
    assign romArr[g] = SAMP_W'(sineVal(g));
  end

  assign rdData = romArr[addr];

endmodule

// File: rtl/fsk_datapath.sv
module fsk_datapath
  import fsk_mod_pkg::*;
#(
  parameter int ACC_W     = 24,
  parameter int IDX_W     = 8,
  parameter int SAMP_W    = 12,
  parameter int SAMPLE_HZ = 9600
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  nco_ctl_t                 ctl,
  input  logic [2:0]               toneSel,
  output logic signed [SAMP_W-1:0] sampleOut,
  output logic                     sampleValid
);

  localparam int NTONES = 8;
  localparam int AMP    = (1 << (SAMP_W - 1)) - 1;

  logic [ACC_W-1:0]         incTab [NTONES];
  logic [ACC_W-1:0]         acc;
  logic [ACC_W-1:0]         stepInc;
  logic signed [SAMP_W-1:0] romData;

  for (genvar g = 0; g < NTONES; g++) begin : g_inc
    localparam logic [2:0] GS = 3'(g);
    assign incTab[g] = ACC_W'(tuneWord(toneHz(GS[2:1], !GS[0]), ACC_W, SAMPLE_HZ));
  end

  assign stepInc = incTab[toneSel];

  fsk_sine_rom #(.IDX_W(IDX_W), .SAMP_W(SAMP_W)) uRom (
    .addr  (acc[ACC_W-1 -: IDX_W]),
    .rdData(romData)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc         <= '0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else if (ctl.clear) begin
      acc         <= '0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else if (ctl.step) begin
      acc         <= acc + stepInc;
      sampleOut   <= romData;
      sampleValid <= 1'b1;
    end else begin
      sampleValid <= 1'b0;
    end
  end

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (acc == '0 && sampleOut == '0 && !sampleValid));

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> sampleValid);

  // R6
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(ctl.step));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.step && !ctl.clear) |=> ($stable(acc) && $stable(sampleOut) && !sampleValid));

  // R6
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (sampleOut <= SAMP_W'(AMP) && sampleOut >= -SAMP_W'(AMP)));

endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod
  import fsk_mod_pkg::*;
#(
  parameter int ACC_W     = 24,
  parameter int IDX_W     = 8,
  parameter int SAMP_W    = 12,
  parameter int SAMPLE_HZ = 9600
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic                     sampleStb,
  input  logic                     dataBit,
  input  logic [1:0]               mode,
  output logic signed [SAMP_W-1:0] sampleOut,
  output logic                     sampleValid
);

  nco_ctl_t   ctl;
  logic [2:0] toneSel;

  fsk_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .sampleStb(sampleStb),
    .dataBit  (dataBit),
    .mode     (mode),
    .ctl      (ctl),
    .toneSel  (toneSel)
  );

  fsk_datapath #(
    .ACC_W    (ACC_W),
    .IDX_W    (IDX_W),
    .SAMP_W   (SAMP_W),
    .SAMPLE_HZ(SAMPLE_HZ)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .toneSel    (toneSel),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid)
  );

endmodule

// File: tb/sim_fsk_tone_mod.sv
module sim_fsk_tone_mod;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              sampleStb = 1'b0;
  logic              dataBit = 1'b0;
  logic [1:0]        mode = 2'd0;
  logic signed [11:0] sampleOut;
  logic              sampleValid;

  int errors = 0;
  int checks = 0;
  longint accM = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fsk_tone_mod u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleStb(sampleStb),
    .dataBit(dataBit), .mode(mode), .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  function automatic longint freqOf(input int m, input bit b);
    case (m)
      0: return b ? 980  : 1180;
      1: return b ? 1650 : 1850;
      2: return b ? 1300 : 2100;
      default: return b ? 390 : 450;
    endcase
  endfunction

  function automatic longint incOf(input int m, input bit b);
    return ((freqOf(m, b) * 64'd16777216) + 64'd4800) / 64'd9600;
  endfunction

  function automatic int expSine(input longint ph);
    real v;
    int idx;
    idx = int'((ph >> 16) & 255);
    v = 2047.0 * $sin(2.0 * 3.14159265358979 * real'(idx) / 256.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One strobe; compare the sample against the phase model, then advance it
  task automatic strobe(input int m, input bit b, input string req);
    int e;
    @(negedge clk);
    mode = 2'(m); dataBit = b; sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
    e = expSine(accM);
    check(sampleValid == 1'b1, req, int'(sampleValid), 1);
    check((int'(sampleOut) - e) <= 1 && (e - int'(sampleOut)) <= 1, req, int'(sampleOut), e);
    accM = (accM + incOf(m, b)) & 64'hFFFFFF;
  endtask

  task automatic idle(input int n);
    logic signed [11:0] last;
    last = sampleOut;
    repeat (n) begin
      @(negedge clk);
      check(sampleValid == 1'b0, "R7 valid", int'(sampleValid), 0);
      check(sampleOut == last, "R7 hold", int'(sampleOut), int'(last));
    end
  endtask

  task automatic finish();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish();
    end
  end

  initial begin
    string tags [4] = '{"R2", "R3", "R4", "R5"};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sampleOut == 0, "R1 sample", int'(sampleOut), 0);
    check(sampleValid == 0, "R1 valid", int'(sampleValid), 0);
    rstN = 1'b1;
    enable = 1'b1;
    @(negedge clk);

    // R2..R5: each mode, each bit, fresh phase from 0
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 2; b++) begin
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1;
        accM = 0;
        for (int k = 0; k < 160; k++) begin
          strobe(m, bit'(b), tags[m]);
          if (k % 37 == 5) idle(2);
        end
      end
    end

    // R8: tone and mode change on strobe edges, phase must carry over
    for (int k = 0; k < 400; k++) begin
      strobe(k % 4, bit'((k / 3) % 2), "R8");
    end

    // R9: disable clears, strobes ignored, restart at zero phase
    @(negedge clk); enable = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); sampleStb = bit'(k % 2);
      check(sampleOut == 0, "R9 zero", int'(sampleOut), 0);
      check(sampleValid == 0, "R9 valid", int'(sampleValid), 0);
    end
    sampleStb = 1'b0; enable = 1'b1;
    accM = 0;
    strobe(2, 1'b0, "R9 restart");
    check(sampleOut == 0, "R9 first", int'(sampleOut), 0);
    for (int k = 0; k < 20; k++) strobe(3, bit'(k % 2), "R9");

    // R10: enable drop coincides with a strobe
    @(negedge clk);
    enable = 1'b0; sampleStb = 1'b1; mode = 2'd1; dataBit = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
    check(sampleValid == 0, "R10 valid", int'(sampleValid), 0);
    check(sampleOut == 0, "R10 zero", int'(sampleOut), 0);
    enable = 1'b1;
    accM = 0;
    strobe(1, 1'b1, "R10 restart");
    strobe(1, 1'b0, "R10");

    done = 1;
    finish();
  end

endmodule